// File: doc/BRIEF.md
# Latched Alarm and Event Status Bank

The bank gathers alarm and event indications from a line receiver. It holds them in latched status registers and presents them to a host through a small synchronous register port. Inputs fall into two groups. An event bit is a pulse that marks something that happened. A level bit is an alarm condition that persists while it holds. Both kinds latch to 1 and stay latched until the host clears them. A level bit is latched again on every cycle its condition is still present.

The host does not read a latched register directly. Each latched register has a held copy, and reads return that copy. A write to the register does two things. For each written 1 whose held copy is 0, the held copy loads the current latched value. For each written 1 whose held copy is 1, the bit counts as reported: the latch and the held copy are both cleared. A written 0 leaves the bit untouched.

The usual poll therefore has three steps: write a selection mask, read the register, then write back the value read ANDed with the mask. Only bits that the host actually saw are cleared. An event arriving during the access is kept for the next poll.

Two of the latched registers can drive the active-low interrupt through per-bit enable registers. An event bit requests while it is latched. A level bit requests after every change of its condition, rising or falling, until it is cleared. A third latched register and a live synchronizer register never interrupt. The live register is read straight from its inputs.

Top module: `stat_regbank`

## Requirements
- R1: After reset all held copies, latches, change flags and both enable registers are 0, `int_n` is 1 and `rd_data` is 0.
- R2: An event input bit that is 1 in any cycle latches its bit. The bit stays latched after the input returns to 0, until it is cleared.
- R3: Address map: 0 status A, 1 status B, 2 info, 3 live, 4 enable A, 5 enable B. In a write to address 0, 1 or 2, a data bit of 1 whose held copy is 0 loads the held copy with the current latched value. A data bit of 0 leaves both the held copy and the latch unchanged.
- R4: A write data bit of 1 whose held copy is 1 clears the latch bit and the held copy bit. A level bit (status A bits 7:4, info bits 3:0) latches again in the next cycle while its condition is still 1.
- R5: An input bit of 1 in the same cycle as a clear of that bit wins: the latch stays 1.
- R6: Address 3 reads `sync_in` as sampled on the read edge, with no latching. Writes to address 3 change nothing.
- R7: An event bit of status A or B that is latched and enabled drives `int_n` to 0. Clearing it releases `int_n` to 1 unless another enabled source remains.
- R8: Every change of a level input, 0 to 1 or 1 to 0, sets a change flag. An enabled flag drives `int_n` to 0 until a clear write to that bit removes it.
- R9: Enable registers A (address 4) and B (address 5) are written and read back whole. A source whose enable bit is 0 never affects `int_n`.
- R10: The info register never affects `int_n`.
- R11: `rd_data` loads the addressed value on the clock edge where `rd_en` is 1 and holds otherwise. Unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sta_in | input | 8 | Status A indications, bits 7:4 level, 3:0 event |
| stb_in | input | 8 | Status B indications, all event |
| inf_in | input | 8 | Info indications, bits 3:0 level, 7:4 event |
| sync_in | input | 8 | Live synchronizer state |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| int_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a new event or a level change on the bit being cleared. It only arises if the input drive is lined up with the clear write of a three-step poll. The bench schedules such collisions on purpose. It also runs a long random phase with sparse inputs, so that polls and input activity overlap in many combinations. A behavioural model, updated every cycle, predicts both `rd_data` and `int_n`.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NIRQ = 3;

  typedef enum logic [AW-1:0] {
    A_STA  = 3'd0,
    A_STB  = 3'd1,
    A_INF  = 3'd2,
    A_LIVE = 3'd3,
    A_IMA  = 3'd4,
    A_IMB  = 3'd5
  } addr_e;
endpackage

// File: rtl/stat_rst_sync.sv
module stat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/stat_latch_reg.sv
module stat_latch_reg #(
  parameter int         W     = 8,
  parameter logic [W-1:0] LEVEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] snap_o,
  output logic [W-1:0] src_o
);
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] snap_q, snap_d;
  logic [W-1:0] clr;

  // Next-state: set has priority over clear
  always_comb begin
    clr    = wr_i ? (wdata_i & snap_q) : '0;
    lat_d  = cond_i | (lat_q & ~clr);
    snap_d = (wdata_i & lat_q & ~clr) | (~wdata_i & snap_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (wr_i) snap_q <= snap_d;
  end

  assign snap_o = snap_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (LEVEL[b]) begin : g_lvl
      logic prev_q, pend_q, pend_d;

      always_comb pend_d = (cond_i[b] ^ prev_q) | (pend_q & ~clr[b]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= cond_i[b];
          pend_q <= pend_d;
        end
      end

      assign src_o[b] = pend_q;

      AST_EDGE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i[b] != prev_q) |=> src_o[b]); // R8
    end else begin : g_evt
      assign src_o[b] = lat_q[b];
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|cond_i) |=> ((lat_q & $past(cond_i)) == $past(cond_i))); // R5

  AST_WR0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(snap_o)); // R3

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((snap_o & $past(wdata_i & snap_o)) == '0)); // R4
endmodule

// File: rtl/stat_irq_merge.sv
module stat_irq_merge #(
  parameter int W    = 8,
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0][W-1:0] src_i,
  input  logic [NSRC-1:0][W-1:0] en_i,
  output logic                   int_n_o
);
  logic [NSRC-1:0] req;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign req[s] = |(src_i[s] & en_i[s]);
  end

  assign int_n_o = ~(|req);
endmodule

// File: rtl/stat_regbank.sv
module stat_regbank
  import stat_pkg::*;
#(
  parameter logic [DW-1:0] LVL_A = 8'hF0,
  parameter logic [DW-1:0] LVL_B = 8'h00,
  parameter logic [DW-1:0] LVL_I = 8'h0F,
  parameter int            RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sta_in,
  input  logic [DW-1:0] stb_in,
  input  logic [DW-1:0] inf_in,
  input  logic [DW-1:0] sync_in,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          int_n
);
  localparam logic [DW-1:0] NO_EN = '0;

  logic          rst_s_n;
  logic          wr_sta, wr_stb, wr_inf, wr_ima, wr_imb;
  logic [DW-1:0] snap_a, snap_b, snap_i;
  logic [DW-1:0] src_a, src_b, src_i;
  logic [DW-1:0] ima_q, imb_q;
  logic [DW-1:0] rd_d, rd_q;

  stat_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n)
  );

  always_comb begin
    wr_sta = wr_en && (addr == A_STA);
    wr_stb = wr_en && (addr == A_STB);
    wr_inf = wr_en && (addr == A_INF);
    wr_ima = wr_en && (addr == A_IMA);
    wr_imb = wr_en && (addr == A_IMB);
  end

  stat_latch_reg #(.W(DW), .LEVEL(LVL_A)) u_sta (
    .clk(clk), .rst_n(rst_s_n), .cond_i(sta_in), .wr_i(wr_sta),
    .wdata_i(wr_data), .snap_o(snap_a), .src_o(src_a)
  );

  stat_latch_reg #(.W(DW), .LEVEL(LVL_B)) u_stb (
    .clk(clk), .rst_n(rst_s_n), .cond_i(stb_in), .wr_i(wr_stb),
    .wdata_i(wr_data), .snap_o(snap_b), .src_o(src_b)
  );

  stat_latch_reg #(.W(DW), .LEVEL(LVL_I)) u_inf (
    .clk(clk), .rst_n(rst_s_n), .cond_i(inf_in), .wr_i(wr_inf),
    .wdata_i(wr_data), .snap_o(snap_i), .src_o(src_i)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    ima_q <= '0;
    else if (wr_ima) ima_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    imb_q <= '0;
    else if (wr_imb) imb_q <= wr_data;
  end

  stat_irq_merge #(.W(DW), .NSRC(NIRQ)) u_irq (
    .src_i({src_i, src_b, src_a}),
    .en_i({NO_EN, imb_q, ima_q}),
    .int_n_o(int_n)
  );

  always_comb begin
    case (addr)
      A_STA:   rd_d = snap_a;
      A_STB:   rd_d = snap_b;
      A_INF:   rd_d = snap_i;
      A_LIVE:  rd_d = sync_in;
      A_IMA:   rd_d = ima_q;
      A_IMB:   rd_d = imb_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ima_q == '0 && imb_q == '0) |-> int_n); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_en |=> $stable(rd_data)); // R11

  AST_LIVE_READ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_en && addr == A_LIVE) |=> (rd_data == $past(sync_in))); // R6
endmodule

// File: tb/stat_regbank_tb.sv
module stat_regbank_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sta_in, stb_in, inf_in, sync_in;
  logic [2:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       int_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // Reference model state
  bit [7:0] lvl  [3] = '{8'hF0, 8'h00, 8'h0F};
  bit [7:0] m_lat [3];
  bit [7:0] m_held[3];
  bit [7:0] m_chg [3];
  bit [7:0] m_prv [3];
  bit [7:0] m_en  [2];
  bit [7:0] m_rd;
  bit       m_int;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .sta_in(sta_in), .stb_in(stb_in),
    .inf_in(inf_in), .sync_in(sync_in), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .int_n(int_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Model one clock edge with the given inputs
  task automatic model_step(input bit [7:0] a, b, i, s, input bit wr, rd,
                            input int ad, input bit [7:0] wd);
    bit [7:0] inp[3];
    bit [7:0] rd_new;
    int       req_cnt;
    inp = '{a, b, i};
    rd_new = m_rd;
    if (rd) begin
      if (ad <= 2)       rd_new = m_held[ad];
      else if (ad == 3)  rd_new = s;
      else if (ad == 4)  rd_new = m_en[0];
      else if (ad == 5)  rd_new = m_en[1];
      else               rd_new = 8'h00;
    end
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 8; k++) begin
        bit sel, seen, cleared;
        sel = wr && (ad == r) && wd[k];
        seen = m_held[r][k];
        cleared = sel && seen;
        if (sel) m_held[r][k] = seen ? 1'b0 : m_lat[r][k];
        if (inp[r][k])     m_lat[r][k] = 1'b1;
        else if (cleared)  m_lat[r][k] = 1'b0;
        if (lvl[r][k]) begin
          if (inp[r][k] != m_prv[r][k]) m_chg[r][k] = 1'b1;
          else if (cleared)             m_chg[r][k] = 1'b0;
          m_prv[r][k] = inp[r][k];
        end
      end
    end
    if (wr && ad == 4) m_en[0] = wd;
    if (wr && ad == 5) m_en[1] = wd;
    m_rd = rd_new;
    req_cnt = 0;
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 8; k++) begin
        bit src;
        src = lvl[r][k] ? m_chg[r][k] : m_lat[r][k];
        if (src && m_en[r][k]) req_cnt++;
      end
    m_int = (req_cnt == 0);
  endtask

  // One cycle: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input bit [7:0] a, b, i, s, input bit wr, rd,
                     input int ad, input bit [7:0] wd, input string req);
    sta_in = a; stb_in = b; inf_in = i; sync_in = s;
    wr_en = wr; rd_en = rd; addr = ad[2:0]; wr_data = wd;
    model_step(a, b, i, s, wr, rd, ad, wd);
    @(negedge clk);
    check(req, rd_data, m_rd, "rd_data");
    check(req, {7'd0, int_n}, {7'd0, m_int}, "int_n");
  endtask

  task automatic idle(input string req);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sta_in = 0; stb_in = 0; inf_in = 0; sync_in = 0;
    addr = 0; wr_en = 0; rd_en = 0; wr_data = 0;
    for (int r = 0; r < 3; r++) begin
      m_lat[r] = 0; m_held[r] = 0; m_chg[r] = 0; m_prv[r] = 0;
    end
    m_en[0] = 0; m_en[1] = 0; m_rd = 0; m_int = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1", rd_data, 8'h00, "rd_data after reset");
    check("R1", {7'd0, int_n}, 8'h01, "int_n after reset");
    for (int ad = 0; ad < 8; ad++) cyc(0, 0, 0, 0, 0, 1, ad, 0, "R1");

    // R9: enable registers write and read back
    cyc(0, 0, 0, 0, 1, 0, 4, 8'hFF, "R9");
    cyc(0, 0, 0, 0, 1, 0, 5, 8'hFF, "R9");
    cyc(0, 0, 0, 0, 0, 1, 4, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 5, 0, "R9");

    // R2 / R7: event pulse latches and interrupts until polled
    cyc(0, 8'h01, 0, 0, 0, 0, 0, 0, "R2");
    idle("R7"); idle("R2");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h01, "R3");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, "R2");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h01, "R4");
    idle("R7");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, "R4");

    // R3: zero mask bits leave held copy and latch alone
    cyc(0, 8'h02, 0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h00, "R3");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, "R3");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h02, "R3");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, "R3");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h00, "R3");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, "R3");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h02, "R4");
    idle("R7");

    // R8 / R4: level alarm rising, held, then falling
    cyc(8'h80, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(8'h80, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(8'h80, 0, 0, 0, 1, 0, 0, 8'h80, "R8");
    cyc(8'h80, 0, 0, 0, 0, 1, 0, 0, "R8");
    cyc(8'h80, 0, 0, 0, 1, 0, 0, 8'h80, "R4");
    cyc(8'h80, 0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(8'h80, 0, 0, 0, 1, 0, 0, 8'h80, "R4");
    cyc(8'h80, 0, 0, 0, 0, 1, 0, 0, "R4");
    cyc(8'h80, 0, 0, 0, 1, 0, 0, 8'h80, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    idle("R8");
    cyc(0, 0, 0, 0, 1, 0, 0, 8'h80, "R8");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R8");
    cyc(0, 0, 0, 0, 1, 0, 0, 8'h80, "R8");
    idle("R8");

    // R5: event collides with clear of the same bit
    cyc(0, 8'h08, 0, 0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h08, "R5");
    cyc(0, 8'h08, 0, 0, 1, 0, 1, 8'h08, "R5");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, "R5");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h08, "R5");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, "R5");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h08, "R5");
    idle("R5");

    // R6: live register
    cyc(0, 0, 0, 8'hA5, 0, 1, 3, 0, "R6");
    cyc(0, 0, 0, 8'h3C, 0, 1, 3, 0, "R6");
    cyc(0, 0, 0, 8'h3C, 1, 0, 3, 8'hFF, "R6");
    cyc(0, 0, 0, 8'h00, 0, 1, 3, 0, "R6");

    // R10: info register never interrupts
    cyc(0, 0, 8'h81, 0, 0, 0, 0, 0, "R10");
    cyc(0, 0, 8'h08, 0, 0, 0, 0, 0, "R10");
    idle("R10");
    cyc(0, 0, 0, 0, 1, 0, 2, 8'hFF, "R10");
    cyc(0, 0, 0, 0, 0, 1, 2, 0, "R10");
    cyc(0, 0, 0, 0, 1, 0, 2, 8'h89, "R10");
    cyc(0, 0, 0, 0, 0, 1, 2, 0, "R10");

    // R9: disabled source ignored, enabling it exposes the latched bit
    cyc(0, 0, 0, 0, 1, 0, 5, 8'h00, "R9");
    cyc(0, 8'h10, 0, 0, 0, 0, 0, 0, "R9");
    idle("R9");
    cyc(0, 0, 0, 0, 1, 0, 5, 8'h10, "R9");
    idle("R9");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h10, "R9");
    cyc(0, 0, 0, 0, 1, 0, 1, 8'h10, "R9");

    // R11: read data holds without rd_en, unused address reads 0
    cyc(0, 0, 0, 0, 0, 1, 4, 0, "R11");
    cyc(0, 0, 0, 0, 1, 0, 4, 8'h55, "R11");
    cyc(0, 0, 0, 8'hEE, 0, 0, 3, 0, "R11");
    cyc(0, 0, 0, 0, 0, 1, 7, 0, "R11");
    cyc(0, 0, 0, 0, 0, 1, 6, 0, "R11");

    // Random phase, R7 and everything else under the model
    for (int n = 0; n < 4000; n++) begin
      bit [7:0] a, b, i, s, wd;
      bit wr, rd;
      int ad;
      a  = 8'($urandom & $urandom & $urandom);
      b  = 8'($urandom & $urandom & $urandom);
      i  = 8'($urandom & $urandom);
      s  = 8'($urandom);
      wr = ($urandom % 3) == 0;
      rd = ($urandom % 2) == 0;
      ad = $urandom % 8;
      wd = 8'($urandom);
      cyc(a, b, i, s, wr, rd, ad, wd, "R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule